// File: doc/BRIEF.md
# Manchester Line Encoder with Sync Preamble

This block turns a serial NRZ bit stream into a complementary pair of Biphase-L (Manchester II) line outputs. It runs from a clock at twice the bit rate, so each cycle carries one half of a bit cell. While a frame is being sent, it also drives a free-running bit-rate clock to the data source. An active-low clear-to-send input opens and closes each frame. When that input falls, the block sends a fixed preamble of logic-0 cells and then a three-cell command sync pulse. It then encodes the incoming bits back to back, with no parity and no word framing, until clear-to-send rises again. The line data is inverted.

The sequencing lives in a four-state machine. `ST_IDLE` holds the line quiet. The falling-edge transition `IDLE->PREAMBLE` starts a frame. `ST_PREAMBLE` counts sixteen half-bits, and its completion transition `PREAMBLE->SYNC` hands over to `ST_SYNC`, which shapes the six half-bits of the command sync pulse. The transition `SYNC->DATA` follows, and `ST_DATA` then alternates first and second half-bits with no end of its own. From any active state, the abort transition `ANY->IDLE` is taken on the first clock edge that sees clear-to-send high.

Top module: `mancx_encoder`

## Requirements
- R1: While idle, `line_pos_o` and `line_neg_o` are both 1 and `bit_clk_o` is 0. The block is idle after reset and on every cycle that follows a clock edge at which `cts_n_i` was 1.
- R2: During a frame, `bit_clk_o` toggles every cycle. It is 1 in the first half of each bit cell and 0 in the second half, so it is never 1 on two cycles in a row.
- R3: On the cycle after the clock edge that first sees `cts_n_i` low following a high level (or reset), the preamble begins. It has 8 logic-0 cells, and on `line_pos_o` each cell is 1 then 0.
- R4: The preamble is followed at once by the command sync pulse: six half-bits that read 0,0,0,1,1,1 on `line_pos_o`.
- R5: A data bit d is sent as the cell ~d then d on `line_pos_o`. This is Biphase-L (logic 1 high-to-low at mid-cell), inverted on the line.
- R6: `nrz_i` is sampled only at the clock edge where `bit_clk_o` falls. The first sample is taken in the third sync cell, and each sample is sent in the cell that immediately follows. Values of `nrz_i` at all other edges have no effect.
- R7: Data cells follow the sync pulse and each other with no gaps, parity or framing, for as long as `cts_n_i` stays low.
- R8: During a frame, `line_neg_o` is the complement of `line_pos_o`. The two line outputs are never both 0.
- R9: If `cts_n_i` rises partway through a cell, the block is idle on the next cycle. The next falling edge restarts the full preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cts_n_i | input | 1 | Active-low clear-to-send; a falling edge starts a frame |
| nrz_i | input | 1 | Serial NRZ data from the source |
| bit_clk_o | output | 1 | Bit-rate clock to the data source, 0 when idle |
| line_pos_o | output | 1 | Inverted Biphase-L line output, 1 when idle |
| line_neg_o | output | 1 | Complement line output, 1 when idle |

## Verification
The hardest situation to reach is a clear-to-send abort that lands on a chosen half-bit of a chosen state, followed at once by a restart. Only that sequence tests whether the edge detector and counters recover fully. The driver counts half-bits from the falling edge, so it can raise `cts_n_i` at an exact point: inside the preamble, or in the first half of a data cell. It then lowers the input again one cycle later and expects a fresh preamble. Sampling is exposed by driving the complement of the intended bit on every non-sampling edge, so a sample taken one edge early or late shows up as inverted line data.

// File: rtl/mancx_pkg.sv
package mancx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_SYNC     = 2'd2,
        ST_DATA     = 2'd3
    } mx_state_t;

    function automatic int mx_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mancx_cts_edge.sv
module mancx_cts_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_i,
    output logic cts_fall_o
);
    logic cts_q;

    // Resets high so that a level held low through reset counts as a fall.
    always_ff @(posedge clk) begin
        if (!rst_n) cts_q <= 1'b1;
        else        cts_q <= cts_n_i;
    end

    always_comb cts_fall_o = cts_q & ~cts_n_i;
endmodule

// File: rtl/mancx_fsm.sv
module mancx_fsm
    import mancx_pkg::*;
#(
    parameter int PRE_BITS  = 8,
    parameter int SYNC_HALF = 3,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_n_i,
    input  logic              cts_fall_i,
    output mx_state_t         state_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              sample_o,
    output logic              load_o
);
    localparam int PRE_LAST  = 2 * PRE_BITS - 1;
    localparam int SYNC_LAST = 2 * SYNC_HALF - 1;

    mx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (state_q != ST_IDLE && cts_n_i) begin
            state_d = ST_IDLE;                      // ANY->IDLE abort
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d = '0;
                    if (cts_fall_i) state_d = ST_PREAMBLE;
                end
                ST_PREAMBLE: begin
                    if (cnt_q == CNT_W'(PRE_LAST)) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (cnt_q == CNT_W'(SYNC_LAST)) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    cnt_d = {{(CNT_W-1){1'b0}}, ~cnt_q[0]};
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Strobes: sample at the mid-cell edge, load at the cell boundary edge.
    always_comb begin
        sample_o = 1'b0;
        load_o   = 1'b0;
        unique case (state_q)
            ST_SYNC: begin
                sample_o = (cnt_q == CNT_W'(SYNC_LAST - 1));
                load_o   = (cnt_q == CNT_W'(SYNC_LAST));
            end
            ST_DATA: begin
                sample_o = ~cnt_q[0];
                load_o   = cnt_q[0];
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/mancx_bit_sampler.sv
module mancx_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_i,
    input  logic sample_i,
    input  logic load_i,
    output logic cur_bit_o
);
    logic next_q, cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= 1'b0;
            cur_q  <= 1'b0;
        end else begin
            if (sample_i) next_q <= nrz_i;
            if (load_i)   cur_q  <= next_q;
        end
    end

    assign cur_bit_o = cur_q;
endmodule

// File: rtl/mancx_line_shaper.sv
module mancx_line_shaper
    import mancx_pkg::*;
#(
    parameter int SYNC_HALF = 3,
    parameter int CNT_W     = 5
) (
    input  mx_state_t        state_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cur_bit_i,
    output logic             bit_clk_o,
    output logic             line_pos_o,
    output logic             line_neg_o
);
    logic first_half;
    logic pos;

    always_comb begin
        first_half = ~cnt_i[0];
        pos        = 1'b1;
        bit_clk_o  = 1'b0;
        unique case (state_i)
            ST_IDLE: begin
                pos       = 1'b1;
                bit_clk_o = 1'b0;
            end
            ST_PREAMBLE: begin
                pos       = first_half;
                bit_clk_o = first_half;
            end
            ST_SYNC: begin
                pos       = (cnt_i >= CNT_W'(SYNC_HALF));
                bit_clk_o = first_half;
            end
            ST_DATA: begin
                pos       = first_half ? ~cur_bit_i : cur_bit_i;
                bit_clk_o = first_half;
            end
            default: ;
        endcase
        line_pos_o = pos;
        line_neg_o = (state_i == ST_IDLE) ? 1'b1 : ~pos;
    end
endmodule

// File: rtl/mancx_encoder.sv
module mancx_encoder
    import mancx_pkg::*;
#(
    parameter int PRE_BITS  = 8,
    parameter int SYNC_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_i,
    input  logic nrz_i,
    output logic bit_clk_o,
    output logic line_pos_o,
    output logic line_neg_o
);
    localparam int CNT_W = $clog2(mx_max(2 * PRE_BITS, 2 * SYNC_HALF) + 1);

    logic             cts_fall;
    mx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic             sample, load, cur_bit;

    mancx_cts_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_n_i    (cts_n_i),
        .cts_fall_o (cts_fall)
    );

    mancx_fsm #(
        .PRE_BITS  (PRE_BITS),
        .SYNC_HALF (SYNC_HALF),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_n_i    (cts_n_i),
        .cts_fall_i (cts_fall),
        .state_o    (state),
        .cnt_o      (cnt),
        .sample_o   (sample),
        .load_o     (load)
    );

    mancx_bit_sampler u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrz_i     (nrz_i),
        .sample_i  (sample),
        .load_i    (load),
        .cur_bit_o (cur_bit)
    );

    mancx_line_shaper #(
        .SYNC_HALF (SYNC_HALF),
        .CNT_W     (CNT_W)
    ) u_shape (
        .state_i    (state),
        .cnt_i      (cnt),
        .cur_bit_i  (cur_bit),
        .bit_clk_o  (bit_clk_o),
        .line_pos_o (line_pos_o),
        .line_neg_o (line_neg_o)
    );
endmodule

// File: rtl/mancx_encoder_chk.sv
module mancx_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic cts_n_i,
    input logic bit_clk_o,
    input logic line_pos_o,
    input logic line_neg_o
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pos_o && line_neg_o) |-> !bit_clk_o); // R1

    AST_CLK_NO_DOUBLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && bit_clk_o) |=> !bit_clk_o); // R2

    AST_PREAMBLE_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(line_pos_o && line_neg_o && !bit_clk_o) && bit_clk_o)
        |-> (line_pos_o && !line_neg_o)); // R3

    AST_RAILS_NOT_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (line_pos_o || line_neg_o)); // R8

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && cts_n_i) |=> (line_pos_o && line_neg_o && !bit_clk_o)); // R9
endmodule

bind mancx_encoder mancx_encoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_n_i    (cts_n_i),
    .bit_clk_o  (bit_clk_o),
    .line_pos_o (line_pos_o),
    .line_neg_o (line_neg_o)
);

// File: tb/mancx_encoder_bench.sv
module mancx_encoder_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n = 1'b1;
    logic nrz = 1'b0;
    logic bclk, lpos, lneg;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // expected {idle, pos, bclk} and requirement tag per cycle
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mancx_encoder u_mancx_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_n_i    (cts_n),
        .nrz_i      (nrz),
        .bit_clk_o  (bclk),
        .line_pos_o (lpos),
        .line_neg_o (lneg)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Monitor: a quarter period after each edge, compare against the oldest item.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, lpos, e[1], "line_pos");
            check("R2", bclk, e[0], "bit_clk");
            check(e[2] ? "R1" : "R8", lneg, e[2] ? 1'b1 : ~e[1], "line_neg");
        end
    end

    // One driven cycle and the output expected after the next edge.
    task automatic cyc(input logic c, input logic d, input logic idle,
                       input logic epos, input logic eclk, input string tag);
        @(negedge clk);
        cts_n = c;
        nrz   = d;
        exp_q.push_back({idle, epos, eclk});
        tag_q.push_back(tag);
    endtask

    // Send a frame of n bits; abort_at >= 0 raises clear-to-send at that half-bit.
    task automatic frame(input logic [31:0] bits, input int n, input int abort_at, input bit restart);
        int h = 0;
        for (int i = 0; i < 16; i++) begin
            if (h == abort_at) begin cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9"); return; end
            cyc(1'b0, ~bits[0], 1'b0, (i % 2 == 0), (i % 2 == 0),
                (restart && i == 0) ? "R9" : "R3");
            h++;
        end
        for (int j = 0; j < 6; j++) begin
            if (h == abort_at) begin cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9"); return; end
            cyc(1'b0, (j == 5) ? bits[0] : ~bits[0], 1'b0, (j >= 3), (j % 2 == 0), "R4");
            h++;
        end
        for (int k = 0; k < n; k++) begin
            logic nb;
            string tg;
            nb = (k + 1 < n) ? bits[k+1] : 1'b0;
            tg = (k == 0) ? "R6" : ((k % 2) ? "R5" : "R7");
            if (h == abort_at) begin cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9"); return; end
            cyc(1'b0, ~nb, 1'b0, ~bits[k], 1'b1, tg);
            h++;
            if (h == abort_at) begin cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9"); return; end
            cyc(1'b0, nb, 1'b0, bits[k], 1'b0, tg);
            h++;
        end
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1", lpos, 1'b1, "reset line_pos");
        check("R1", lneg, 1'b1, "reset line_neg");
        check("R1", bclk, 1'b0, "reset bit_clk");
        rst_n = 1'b1;
        // R1: idle with data toggling
        for (int i = 0; i < 4; i++) cyc(1'b1, i[0], 1'b1, 1'b1, 1'b0, "R1");
        frame(32'b0100_1101, 8, -1, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1");
        frame(32'hF, 4, -1, 1'b0);
        frame(32'b1010_1010_0101, 12, -1, 1'b0);
        // abort mid-preamble, restart at once (R9)
        frame(32'h5, 3, 5, 1'b0);
        frame(32'b0110, 4, -1, 1'b1);
        // abort in first half of a data cell, restart
        frame(32'b1101, 4, 22 + 4, 1'b0);
        frame(32'b0001, 4, -1, 1'b1);
        for (int i = 0; i < 4; i++) cyc(1'b1, ~i[0], 1'b1, 1'b1, 1'b0, "R1");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule